// File: doc/BRIEF.md
# Bit-rate UART frame transmitter

This block turns a plain synchronous shifter, clocked once per bit period, into an asynchronous UART transmit line. A host sets the data-word length, the bit-period divider and the number of words in a transfer. It then raises the enable input. Each time the data-request output is high, the host presents one word together with a one-cycle write strobe. The word is masked to the chosen length and wrapped into a packet. The packet is then shifted out LSB first on a single serial output, one bit per bit tick.

A shifter of this kind leaves its output at the value of the last bit it shifted. Each packet therefore begins with an extra high guard bit and ends with a high stop bit, so the line rests high between words and never dips low by accident. The line is low out of reset, and it is low again after the first enable until the first guard bit is shifted. A downstream receiver therefore sees one all-zero frame first, and the system has to discard it. Once the programmed number of words has been sent, the block disables itself and holds a done flag until enable is lowered.

Top module: `uart_sync_tx`

## Requirements
- R1: The bit timer runs only while busy. A bit tick occurs every 2*(half_div+1) clock cycles, counted from the first busy cycle. `txd` changes only in the cycle after a tick.
- R2: Data bits leave the line least significant bit first.
- R3: The packet is, in shift order, a guard bit 1, a start bit 0, the data bits, and a stop bit 1, for word_len+3 bits in total. word_len values below 5 act as 5 and values above 8 act as 8. Data bits at and above the effective length are dropped.
- R4: After reset `txd` is 0, and it stays 0 after enable until the first guard bit is shifted.
- R5: Between shifted bits, and after a packet ends, `txd` holds the last shifted value, which is 1 after any packet. At a tick with the shifter empty and a word held, the word is loaded and no bit is shifted. Back-to-back packets are therefore spaced by one idle tick.
- R6: `data_req` is high exactly when the block is busy, the one-word holding register is empty, and words_sent is below xfer_count. A write strobe while `data_req` is low is ignored.
- R7: `words_sent` counts the words moved into the shifter. At the first tick where the shifter and the holding register are both empty and words_sent equals xfer_count, busy falls and done rises. A count of zero ends at the first tick with nothing sent.
- R8: Lowering enable while busy drops busy in the next cycle and leaves `txd` unchanged.
- R9: With enable high, busy low and done low, busy rises in the next cycle and words_sent and the holding register are cleared. Done stays high until enable is low for a cycle.
- R10: A synchronous active-high reset clears busy, done, data_req, words_sent and `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Starts a transfer; low aborts it or re-arms after done |
| half_div | input | DIV_W | Half-period divider value; bit period is 2*(half_div+1) cycles |
| word_len | input | 4 | Data bits per word, effective 5 to 8 |
| xfer_count | input | CNT_W | Words in the transfer |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Data word |
| data_req | output | 1 | Holding register can take the next word |
| txd | output | 1 | Serial UART line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed, held until enable is low |
| words_sent | output | CNT_W | Words moved into the shifter this transfer |

## Verification
The bench builds the block with DIV_W=4 and CNT_W=4. At that size the largest divider value (15, a 32-cycle bit) and the full-scale count of 15 words both fit into short runs. The run also covers both ends of the word-length clamp, a zero count, an abort during a packet, a reset during a transfer and a host that stalls between words. A behavioural model built from queues predicts the line, the request flag and the counters on every clock.

// File: rtl/uart_sync_tx_pkg.sv
package uart_sync_tx_pkg;
    localparam int MAX_LEN = 8;
    localparam int MIN_LEN = 5;
    localparam int LEN_W   = 4;
    localparam int PKT_W   = MAX_LEN + 3;

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(MIN_LEN))      return LEN_W'(MIN_LEN);
        else if (raw > LEN_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
        else                            return raw;
    endfunction
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last_count;

    assign last_count = {half_div, 1'b1};
    assign tick       = run && (cnt_q == last_count);

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tx_frame_pack.sv
module tx_frame_pack
    import uart_sync_tx_pkg::*;
(
    input  logic [MAX_LEN-1:0] data,
    input  logic [LEN_W-1:0]   word_len,
    output logic [PKT_W-1:0]   pkt,
    output logic [LEN_W-1:0]   nbits
);
    logic [LEN_W-1:0] len_eff;

    assign len_eff = eff_len(word_len);
    assign nbits   = len_eff + LEN_W'(3);

    assign pkt[0]       = 1'b1;
    assign pkt[1]       = 1'b0;
    assign pkt[PKT_W-1] = 1'b1;

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_bit
        localparam logic [LEN_W-1:0] POS = LEN_W'(i);
        assign pkt[2+i] = (POS < len_eff) ? data[i] : 1'b1;
    end
endmodule

// File: rtl/uart_sync_tx.sv
module uart_sync_tx
    import uart_sync_tx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] half_div,
    input  logic [3:0]       word_len,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             data_req,
    output logic             txd,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] words_sent
);
    typedef struct packed {
        logic             run;
        logic             done;
        logic             hold_full;
        logic [PKT_W-1:0] hold_pkt;
        logic [LEN_W-1:0] hold_n;
        logic [PKT_W-1:0] shift;
        logic [LEN_W-1:0] left;
        logic             line;
        logic [CNT_W-1:0] loaded;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic             bit_tick;
    logic [PKT_W-1:0] new_pkt;
    logic [LEN_W-1:0] new_n;

    tx_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (st_q.run),
        .half_div (half_div),
        .tick     (bit_tick)
    );

    tx_frame_pack u_pack (
        .data     (wr_data),
        .word_len (word_len),
        .pkt      (new_pkt),
        .nbits    (new_n)
    );

    assign data_req   = st_q.run && !st_q.hold_full && (st_q.loaded < xfer_count);
    assign txd        = st_q.line;
    assign busy       = st_q.run;
    assign done       = st_q.done;
    assign words_sent = st_q.loaded;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (enable && !st_q.done) begin
                st_d.run       = 1'b1;
                st_d.loaded    = '0;
                st_d.hold_full = 1'b0;
                st_d.left      = '0;
            end
            if (!enable) st_d.done = 1'b0;
        end else if (!enable) begin
            st_d.run = 1'b0;
        end else begin
            if (bit_tick) begin
                if (st_q.left != '0) begin
                    st_d.line  = st_q.shift[0];
                    st_d.shift = st_q.shift >> 1;
                    st_d.left  = st_q.left - LEN_W'(1);
                end else if (st_q.hold_full) begin
                    st_d.shift     = st_q.hold_pkt;
                    st_d.left      = st_q.hold_n;
                    st_d.hold_full = 1'b0;
                    st_d.loaded    = st_q.loaded + CNT_W'(1);
                end else if (st_q.loaded == xfer_count) begin
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end
            end
            if (wr_valid && data_req) begin
                st_d.hold_full = 1'b1;
                st_d.hold_pkt  = new_pkt;
                st_d.hold_n    = new_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/uart_sync_tx_chk.sv
module uart_sync_tx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             data_req,
    input logic             txd,
    input logic             tick,
    input logic [CNT_W-1:0] words_sent,
    input logic [CNT_W-1:0] xfer_count
);
    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (txd != $past(txd))) |-> $past(tick)); // R1
    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        data_req |-> (busy && words_sent < xfer_count)); // R6
    AST_IDLE_LINE_STEADY: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(txd)); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(done && busy)); // R7
    AST_SENT_WITHIN_COUNT: assert property (@(posedge clk) disable iff (rst)
        busy |-> (words_sent <= xfer_count)); // R7
    AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (done && words_sent != '0) |-> txd); // R5
endmodule

bind uart_sync_tx uart_sync_tx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .data_req   (data_req),
    .txd        (txd),
    .tick       (bit_tick),
    .words_sent (words_sent),
    .xfer_count (xfer_count)
);

// File: tb/uart_sync_tx_test.sv
module uart_sync_tx_test;
    localparam int DIV_W = 4;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [DIV_W-1:0] half_div = '0;
    logic [3:0]       word_len = 4'd8;
    logic [CNT_W-1:0] xfer_count = '0;
    logic             wr_valid = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             data_req, txd, busy, done;
    logic [CNT_W-1:0] words_sent;

    int n_checks = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    uart_sync_tx #(.DIV_W(DIV_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .enable(enable), .half_div(half_div),
        .word_len(word_len), .xfer_count(xfer_count), .wr_valid(wr_valid),
        .wr_data(wr_data), .data_req(data_req), .txd(txd), .busy(busy),
        .done(done), .words_sent(words_sent)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit m_run, m_done, m_line;
    int m_cnt, m_loaded;
    bit m_shift[$];
    bit m_hold[$];
    bit m_hold_ok;

    function automatic bit model_req();
        return m_run && !m_hold_ok && (m_loaded < int'(xfer_count));
    endfunction

    function automatic int clamp_len(input int raw);
        if (raw < 5) return 5;
        if (raw > 8) return 8;
        return raw;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_done = 0; m_line = 0; m_cnt = 0; m_loaded = 0;
            m_shift.delete(); m_hold.delete(); m_hold_ok = 0;
        end else begin
            automatic int  period_end = 2 * int'(half_div) + 1;
            automatic bit  req  = model_req();
            automatic bit  tick = m_run && (m_cnt == period_end);
            automatic int  next_cnt = (!m_run || tick) ? 0 : m_cnt + 1;
            if (!m_run) begin
                if (enable && !m_done) begin
                    m_run = 1; m_loaded = 0; m_hold_ok = 0;
                    m_hold.delete(); m_shift.delete();
                end
                if (!enable) m_done = 0;
            end else if (!enable) begin
                m_run = 0;
            end else begin
                if (tick) begin
                    if (m_shift.size() != 0) m_line = m_shift.pop_front();
                    else if (m_hold_ok) begin
                        m_shift = m_hold; m_hold.delete(); m_hold_ok = 0; m_loaded++;
                    end else if (m_loaded == int'(xfer_count)) begin
                        m_run = 0; m_done = 1;
                    end
                end
                if (wr_valid && req) begin
                    automatic int len = clamp_len(int'(word_len));
                    m_hold.delete();
                    m_hold.push_back(1'b1);
                    m_hold.push_back(1'b0);
                    for (int b = 0; b < len; b++) m_hold.push_back(wr_data[b]);
                    m_hold.push_back(1'b1);
                    m_hold_ok = 1;
                end
            end
            m_cnt = next_cnt;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R2 R3 R5 txd", int'(txd), int'(m_line));
            chk("R6 data_req", int'(data_req), int'(model_req()));
            chk("R8 R9 busy", int'(busy), int'(m_run));
            chk("R7 done", int'(done), int'(m_done));
            chk("R7 words_sent", int'(words_sent), m_loaded);
        end
    end

    task automatic feed(input int count, input int base, input int gap, input bit extra);
        for (int k = 0; k < count; k++) begin
            while (!data_req) @(negedge clk);
            repeat (gap) @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = 8'(base + k * 37);
            @(negedge clk);
            if (extra) begin
                wr_data = 8'(base + k * 37 + 90);
                @(negedge clk);
            end
            wr_valid = 1'b0;
        end
    endtask

    task automatic finish_run(input int count);
        while (!done) @(negedge clk);
        chk("R7 done after count", int'(done), 1);
        chk("R7 words_sent at end", int'(words_sent), count);
        if (count > 0) chk("R5 line high after transfer", int'(txd), 1);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 done cleared by enable low", int'(done), 0);
    endtask

    task automatic start(input int div, input int len, input int count);
        half_div   = DIV_W'(div);
        word_len   = 4'(len);
        xfer_count = CNT_W'(count);
        enable     = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R10 reset state
        chk("R10 txd after reset", int'(txd), 0);
        chk("R10 busy after reset", int'(busy), 0);
        chk("R10 data_req after reset", int'(data_req), 0);
        chk("R10 words_sent after reset", int'(words_sent), 0);

        // R1 R4: first transfer, bit period and the low line before the guard bit
        start(3, 8, 2);
        chk("R9 busy one cycle after enable", int'(busy), 1);
        chk("R4 line low after enable", int'(txd), 0);
        fork
            feed(2, 8'h96, 0, 1'b1);
            begin
                automatic int cyc = 0;
                while (!txd) @(negedge clk);
                while (txd) begin @(negedge clk); cyc++; end
                chk("R1 bit period for half_div 3", cyc, 8);
            end
        join
        finish_run(2);

        // R3 R2: short word, masked high bits
        start(0, 5, 3);
        feed(3, 8'hFF, 0, 1'b0);
        finish_run(3);

        // R3: clamps at both ends
        start(1, 2, 2);
        feed(2, 8'h5A, 1, 1'b0);
        finish_run(2);
        start(1, 13, 2);
        feed(2, 8'hC3, 0, 1'b0);
        finish_run(2);

        // R5: host stalls between words, line rests high
        start(1, 6, 3);
        feed(3, 8'h21, 40, 1'b1);
        finish_run(3);

        // R1: largest divider, R7 largest count
        start(15, 7, 1);
        feed(1, 8'h4D, 0, 1'b0);
        finish_run(1);
        start(0, 5, 15);
        feed(15, 8'h03, 0, 1'b0);
        finish_run(15);

        // R7: zero count
        start(2, 8, 0);
        finish_run(0);

        // R8: abort while shifting
        start(1, 8, 3);
        feed(1, 8'hA5, 0, 1'b0);
        repeat (20) @(negedge clk);
        begin
            automatic logic line_before = txd;
            enable = 1'b0;
            @(negedge clk);
            chk("R8 busy drops on abort", int'(busy), 0);
            chk("R8 line held on abort", int'(txd), int'(line_before));
        end
        @(negedge clk);

        // R10: reset during a transfer
        start(1, 8, 3);
        feed(1, 8'h3C, 0, 1'b0);
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        enable = 1'b0;
        chk("R10 busy after mid-run reset", int'(busy), 0);
        chk("R10 txd after mid-run reset", int'(txd), 0);
        chk("R10 words_sent after mid-run reset", int'(words_sent), 0);
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule